// File: doc/BRIEF.md
# Grouped Arbitrating Request Concentrator

This block merges `NUM_IN` request streams onto `NUM_OUT` output streams. Inputs are split into contiguous groups of `GROUP = NUM_IN/NUM_OUT`. Input `j` belongs to output `j / GROUP` and has local index `j % GROUP` within that group. Each output has its own arbiter. In every cycle the arbiter accepts at most one valid request from its group and pushes the payload, unchanged, into a stall-able delay line of `LATENCY` stages. Both sides use valid/ready handshakes. When `NUM_IN == NUM_OUT` the block is plain wiring.

The arbitration policy is an elaboration-time parameter, and `GROUP` must be a power of two.
- **ARB_FIXED**: the lowest local index always wins.
- **ARB_ROTATE**: round-robin. The state of each output is its search cursor, with one state `CUR_k` per local index `k`.
  - Reset puts every cursor in `CUR_0`.
  - The transition *grant at k* moves the cursor from its current state to `CUR_(k+1) mod GROUP`.
  - The transition *stall* (output not ready) keeps the current state.
  - Each search starts at the cursor and wraps modulo `GROUP`.

Each delay stage has two states, *empty* and *holding*. When the output is ready, each stage takes the contents of the stage before it, and the first stage takes the new grant or a bubble. When the output is not ready, every stage keeps its contents.

Top module: `grpmux_concentrator`

## Requirements
- R1: An input is accepted only by the output of its own group (output `j / GROUP`), and a payload leaves only on that output.
- R2: In any cycle, at most one input of a group sees `in_ready` high. `in_ready` is high only for an input that is valid.
- R3: With `POLICY = ARB_FIXED`, among the valid inputs of a group the lowest local index is accepted.
- R4: With `POLICY = ARB_ROTATE`, after local index `k` is accepted, the next search of that group begins at `(k+1) mod GROUP`. Valid inputs are served in rotating order from there.
- R5: After reset every cursor is 0, so the first acceptance in a fully requesting group goes to local index 0.
- R6: While `out_ready[o]` is low, group `o` accepts nothing and keeps its cursor. `out_valid[o]` and the payload on `out_data[o]` stay unchanged.
- R7: A request accepted in cycle t (sampled with `in_valid` and `in_ready` high) is presented on its output in cycle t+`LATENCY`, provided the output stays ready.
- R8: When `NUM_IN == NUM_OUT`, `out_valid`, `out_data` and `in_ready` equal `in_valid`, `in_data` and `out_ready` combinationally, index by index.
- R9: Payloads pass through unmodified. Input `j` occupies bits `j*PAYLOAD_W +: PAYLOAD_W` of `in_data`, and output `o` occupies bits `o*PAYLOAD_W +: PAYLOAD_W` of `out_data`.
- R10: During and right after reset, every `out_valid` bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | NUM_IN | Request pending, one bit per input |
| in_data | input | NUM_IN*PAYLOAD_W | Flattened input payloads |
| in_ready | output | NUM_IN | Request accepted this cycle, one bit per input |
| out_valid | output | NUM_OUT | Output payload present |
| out_data | output | NUM_OUT*PAYLOAD_W | Flattened output payloads |
| out_ready | input | NUM_OUT | Downstream accepts the output; also advances that output's delay line |

## Verification
The assertions assume that a requester holds `in_valid` and its payload steady until the request is accepted. They also assume that `out_ready` is the only stall source of each delay line. The bench drives inputs only after a clock edge and lowers a valid bit only in the cycle after its acceptance. It changes `out_ready` only between edges. Stalls are applied both while requests are pending and while a payload sits at the output, so the hold properties are exercised.

// File: rtl/grpmux_pkg.sv
package grpmux_pkg;

    // Arbitration policy chosen at elaboration time.
    typedef enum logic {
        ARB_FIXED  = 1'b0,
        ARB_ROTATE = 1'b1
    } arb_policy_e;

    // Index width that never collapses to zero bits.
    function automatic int idx_width(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/grpmux_arbiter.sv
module grpmux_arbiter
    import grpmux_pkg::*;
#(
    parameter int          GROUP  = 4,
    parameter arb_policy_e POLICY = ARB_ROTATE,
    localparam int         IDX_W  = idx_width(GROUP)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [GROUP-1:0] req,
    input  logic             enable,
    output logic [GROUP-1:0] grant,
    output logic [IDX_W-1:0] grant_idx,
    output logic             grant_any
);

    logic [IDX_W-1:0] cursor_q;

    // Search from the cursor, wrapping modulo GROUP; first pending request wins.
    always_comb begin
        logic [IDX_W-1:0] probe;
        grant     = '0;
        grant_idx = '0;
        grant_any = 1'b0;
        probe     = '0;
        for (int r = 0; r < GROUP; r++) begin
            probe = IDX_W'((int'(cursor_q) + r) % GROUP);
            if (!grant_any && enable && req[probe]) begin
                grant_any    = 1'b1;
                grant[probe] = 1'b1;
                grant_idx    = probe;
            end
        end
    end

    // Cursor state: rotating policy moves it past each grant, fixed policy pins it.
    if (POLICY == ARB_ROTATE) begin : g_rotate
        always_ff @(posedge clk) begin
            if (rst) begin
                cursor_q <= '0;
            end else if (grant_any) begin
                cursor_q <= IDX_W'((int'(grant_idx) + 1) % GROUP);
            end
        end

        assert_rotate_step_R4: assert property (@(posedge clk) disable iff (rst)
            grant_any |=> (int'(cursor_q) == (int'($past(grant_idx)) + 1) % GROUP));

        assert_cursor_hold_R6: assert property (@(posedge clk) disable iff (rst)
            !enable |=> $stable(cursor_q));
    end else begin : g_fixed
        assign cursor_q = '0;

        for (genvar k = 1; k < GROUP; k++) begin : g_low
            assert_lowest_wins_R3: assert property (@(posedge clk) disable iff (rst)
                grant[k] |-> ((req & ~({GROUP{1'b1}} << k)) == '0));
        end
    end

    assert_one_grant_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_grant_valid_R2: assert property (@(posedge clk) disable iff (rst)
        ((grant & ~req) == '0));

endmodule

// File: rtl/grpmux_stage.sv
module grpmux_stage #(
    parameter int PAYLOAD_W = 16,
    parameter int LATENCY   = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 advance,
    input  logic                 in_valid,
    input  logic [PAYLOAD_W-1:0] in_data,
    output logic                 out_valid,
    output logic [PAYLOAD_W-1:0] out_data
);

    // Each stage is either empty or holding; the whole line moves only on advance.
    for (genvar k = 0; k < LATENCY; k++) begin : g_st
        logic                 v;
        logic [PAYLOAD_W-1:0] d;
        logic                 prev_v;
        logic [PAYLOAD_W-1:0] prev_d;

        if (k == 0) begin : g_head
            assign prev_v = in_valid;
            assign prev_d = in_data;
        end else begin : g_tail
            assign prev_v = g_st[k-1].v;
            assign prev_d = g_st[k-1].d;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                v <= 1'b0;
            end else if (advance) begin
                v <= prev_v;
            end
        end

        always_ff @(posedge clk) begin
            if (advance) begin
                d <= prev_d;
            end
        end
    end

    assign out_valid = g_st[LATENCY-1].v;
    assign out_data  = g_st[LATENCY-1].d;

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !advance) |=> (out_valid && $stable(out_data)));

    assert_stall_empty_R6: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !advance) |=> !out_valid);

endmodule

// File: rtl/grpmux_concentrator.sv
module grpmux_concentrator
    import grpmux_pkg::*;
#(
    parameter int          NUM_IN    = 8,
    parameter int          NUM_OUT   = 2,
    parameter int          PAYLOAD_W = 16,
    parameter int          LATENCY   = 2,
    parameter arb_policy_e POLICY    = ARB_ROTATE
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_IN-1:0]              in_valid,
    input  logic [NUM_IN*PAYLOAD_W-1:0]    in_data,
    output logic [NUM_IN-1:0]              in_ready,
    output logic [NUM_OUT-1:0]             out_valid,
    output logic [NUM_OUT*PAYLOAD_W-1:0]   out_data,
    input  logic [NUM_OUT-1:0]             out_ready
);

    localparam int GROUP = NUM_IN / NUM_OUT;
    localparam int IDX_W = idx_width(GROUP);

    if (NUM_IN == NUM_OUT) begin : g_wire
        // One input per output: no arbitration, no delay.
        assign out_valid = in_valid;
        assign out_data  = in_data;
        assign in_ready  = out_ready;
    end else begin : g_groups
        for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
            logic [GROUP-1:0]     req;
            logic [GROUP-1:0]     grant;
            logic [IDX_W-1:0]     gidx;
            logic                 gany;
            logic [PAYLOAD_W-1:0] sel;

            assign req = in_valid[o*GROUP +: GROUP];
            assign in_ready[o*GROUP +: GROUP] = grant;

            grpmux_arbiter #(
                .GROUP  (GROUP),
                .POLICY (POLICY)
            ) i_arb (
                .clk       (clk),
                .rst       (rst),
                .req       (req),
                .enable    (out_ready[o]),
                .grant     (grant),
                .grant_idx (gidx),
                .grant_any (gany)
            );

            always_comb begin
                sel = in_data[(o*GROUP + int'(gidx))*PAYLOAD_W +: PAYLOAD_W];
            end

            grpmux_stage #(
                .PAYLOAD_W (PAYLOAD_W),
                .LATENCY   (LATENCY)
            ) i_stage (
                .clk       (clk),
                .rst       (rst),
                .advance   (out_ready[o]),
                .in_valid  (gany),
                .in_data   (sel),
                .out_valid (out_valid[o]),
                .out_data  (out_data[o*PAYLOAD_W +: PAYLOAD_W])
            );
        end

        for (genvar j = 0; j < NUM_IN; j++) begin : g_route
            assert_group_route_R1: assert property (@(posedge clk) disable iff (rst)
                in_ready[j] |-> (out_ready[j/GROUP] && in_valid[j]));
        end

        assert_reset_quiet_R10: assert property (@(posedge clk)
            $past(rst) |-> (out_valid == '0));
    end

endmodule

// File: tb/test_grpmux_concentrator.sv
`timescale 1ns/1ps
module test_grpmux_concentrator;
    import grpmux_pkg::*;

    localparam int N  = 8;
    localparam int M  = 2;
    localparam int W  = 16;
    localparam int L  = 2;
    localparam int R  = N / M;
    localparam int NB = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    // Rotating instance
    logic [N-1:0]   m_iv = '0;
    logic [N*W-1:0] m_id = '0;
    logic [N-1:0]   m_ir;
    logic [M-1:0]   m_ov;
    logic [M*W-1:0] m_od;
    logic [M-1:0]   m_or = '0;
    // Fixed-priority instance
    logic [N-1:0]   p_iv = '0;
    logic [N*W-1:0] p_id = '0;
    logic [N-1:0]   p_ir;
    logic [M-1:0]   p_ov;
    logic [M*W-1:0] p_od;
    logic [M-1:0]   p_or = '0;
    // Wiring instance
    logic [NB-1:0]   b_iv = '0;
    logic [NB*W-1:0] b_id = '0;
    logic [NB-1:0]   b_ir;
    logic [NB-1:0]   b_ov;
    logic [NB*W-1:0] b_od;
    logic [NB-1:0]   b_or = '0;

    grpmux_concentrator #(.NUM_IN(N), .NUM_OUT(M), .PAYLOAD_W(W), .LATENCY(L),
                          .POLICY(ARB_ROTATE)) i_grpmux_concentrator (
        .clk(clk), .rst(rst), .in_valid(m_iv), .in_data(m_id), .in_ready(m_ir),
        .out_valid(m_ov), .out_data(m_od), .out_ready(m_or));

    grpmux_concentrator #(.NUM_IN(N), .NUM_OUT(M), .PAYLOAD_W(W), .LATENCY(L),
                          .POLICY(ARB_FIXED)) i_grpmux_concentrator_fixed (
        .clk(clk), .rst(rst), .in_valid(p_iv), .in_data(p_id), .in_ready(p_ir),
        .out_valid(p_ov), .out_data(p_od), .out_ready(p_or));

    grpmux_concentrator #(.NUM_IN(NB), .NUM_OUT(NB), .PAYLOAD_W(W), .LATENCY(L),
                          .POLICY(ARB_ROTATE)) i_grpmux_concentrator_wire (
        .clk(clk), .rst(rst), .in_valid(b_iv), .in_data(b_id), .in_ready(b_ir),
        .out_valid(b_ov), .out_data(b_od), .out_ready(b_or));

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    int m_pend[N];
    int m_seq[N];
    int m_fcyc[N];
    int p_pend[N];
    int p_seq[N];
    int m_gq[M][$];
    int m_oq[M][$];
    int m_oc[M][$];
    int p_gq[M][$];

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_q(input string tag, input int got[$], input int exp[$]);
        check({tag, " length"}, got.size(), exp.size());
        for (int i = 0; i < exp.size() && i < got.size(); i++) begin
            check($sformatf("%s item %0d", tag, i), got[i], exp[i]);
        end
    endtask

    task automatic clear_logs();
        for (int o = 0; o < M; o++) begin
            m_gq[o].delete(); m_oq[o].delete(); m_oc[o].delete(); p_gq[o].delete();
        end
    endtask

    task automatic load_m(input int j, input int count);
        m_pend[j] = count;
        m_id[j*W +: W] = W'(j*256 + m_seq[j]);
        m_iv[j] = (count > 0);
    endtask

    task automatic load_p(input int j, input int count);
        p_pend[j] = count;
        p_id[j*W +: W] = W'(j*256 + p_seq[j]);
        p_iv[j] = (count > 0);
    endtask

    // One cycle: observe at the falling edge, then update drivers after the rising edge.
    task automatic step();
        logic [N-1:0] fm;
        logic [N-1:0] fp;
        @(negedge clk);
        cyc++;
        fm = m_iv & m_ir;
        fp = p_iv & p_ir;
        for (int o = 0; o < M; o++) begin
            if (m_ov[o] && m_or[o]) begin
                m_oq[o].push_back(int'(m_od[o*W +: W]));
                m_oc[o].push_back(cyc);
            end
        end
        for (int j = 0; j < N; j++) begin
            if (fm[j]) begin m_gq[j/R].push_back(j); m_fcyc[j] = cyc; end
            if (fp[j]) p_gq[j/R].push_back(j);
        end
        @(posedge clk);
        #1;
        for (int j = 0; j < N; j++) begin
            if (fm[j]) begin m_pend[j]--; m_seq[j]++; load_m(j, m_pend[j]); end
            if (fp[j]) begin p_pend[j]--; p_seq[j]++; load_p(j, p_pend[j]); end
        end
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1;
        check("R10 out_valid in reset", int'(m_ov), 0);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R10 out_valid after reset", int'(m_ov), 0);
        check("R10 fixed out_valid after reset", int'(p_ov), 0);
        check("R2 no ready when idle", int'(m_ir), 0);
        m_or = '1;
        p_or = '1;
    endtask

    task automatic t_rotate_full();
        int eg[$];
        int eo[$];
        int none[$];
        clear_logs();
        for (int j = 0; j < R; j++) load_m(j, 2);
        steps(12);
        eg = {0, 1, 2, 3, 0, 1, 2, 3};
        eo = {'h000, 'h100, 'h200, 'h300, 'h001, 'h101, 'h201, 'h301};
        check("R5 first grant after reset", (m_gq[0].size() > 0) ? m_gq[0][0] : -1, 0);
        check_q("R4 rotating order group0", m_gq[0], eg);
        check_q("R9 payloads on output0", m_oq[0], eo);
        check_q("R1 nothing on output1", m_oq[1], none);
    endtask

    task automatic t_rotate_skip();
        int eg[$];
        clear_logs();
        load_m(2, 1);
        steps(4);
        load_m(0, 1);
        load_m(3, 1);
        steps(5);
        eg = {2, 3, 0};
        check_q("R4 resume after index 2", m_gq[0], eg);
    endtask

    task automatic t_latency();
        clear_logs();
        load_m(5, 1);
        steps(6);
        check("R1 output1 count", m_oq[1].size(), 1);
        if (m_oq[1].size() == 1) begin
            check("R9 payload from input5", m_oq[1][0], 'h500);
            check("R7 latency cycles", m_oc[1][0] - m_fcyc[5], L);
        end
        check("R1 output0 silent", m_oq[0].size(), 0);
    endtask

    task automatic t_stall_pending();
        int eg[$];
        int e0[$];
        clear_logs();
        m_or[1] = 1'b0;
        for (int j = R; j < 2*R; j++) load_m(j, 1);
        load_m(1, 1);
        steps(5);
        check("R6 no grant while stalled", m_gq[1].size(), 0);
        check("R6 group1 ready low", int'(m_ir[2*R-1:R]), 0);
        check("R6 output1 quiet", int'(m_ov[1]), 0);
        e0 = {1};
        check_q("R1 group0 unaffected", m_gq[0], e0);
        m_or[1] = 1'b1;
        steps(10);
        eg = {6, 7, 4, 5};
        check_q("R6 cursor held through stall", m_gq[1], eg);
    endtask

    task automatic t_stall_output();
        logic [W-1:0] held;
        int tries;
        clear_logs();
        load_m(0, 1);
        tries = 0;
        while (!m_ov[0] && tries < 10) begin step(); tries++; end
        m_or[0] = 1'b0;
        held = m_od[W-1:0];
        steps(3);
        check("R6 out_valid held", int'(m_ov[0]), 1);
        check("R6 out_data held", int'(m_od[W-1:0]), int'(held));
        m_or[0] = 1'b1;
        steps(2);
        check("R6 delivered once after release", m_oq[0].size(), 1);
    endtask

    task automatic t_fixed();
        int eg[$];
        clear_logs();
        for (int j = 0; j < R; j++) load_p(j, 2);
        steps(12);
        eg = {0, 0, 1, 1, 2, 2, 3, 3};
        check_q("R3 fixed order group0", p_gq[0], eg);
        clear_logs();
        load_p(6, 1);
        load_p(5, 1);
        steps(4);
        eg = {5, 6};
        check_q("R3 fixed order group1", p_gq[1], eg);
    endtask

    task automatic t_wire();
        b_iv = 4'b0101;
        b_id = 64'h1111_2222_3333_4444;
        b_or = 4'b0011;
        #1;
        check("R8 valid passthrough", int'(b_ov), 'b0101);
        check("R8 data passthrough", int'(b_od[31:0]), 'h3333_4444);
        check("R8 ready passthrough", int'(b_ir), 'b0011);
        b_iv = 4'b1010;
        b_or = 4'b1100;
        #1;
        check("R8 valid second pattern", int'(b_ov), 'b1010);
        check("R8 ready second pattern", int'(b_ir), 'b1100);
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int j = 0; j < N; j++) begin
            m_pend[j] = 0; m_seq[j] = 0; p_pend[j] = 0; p_seq[j] = 0; m_fcyc[j] = 0;
        end
        t_reset();
        t_rotate_full();
        t_rotate_skip();
        t_latency();
        t_stall_pending();
        t_stall_output();
        t_fixed();
        t_wire();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule